// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command pins of a two-bank, 16-bit-wide SDRAM from the moment reset is applied until the memory may take normal traffic. While the rest of the chip waits, it keeps the clock enable and both byte masks high and presents no-operation commands for a settle time long enough for the supply and clock to become stable. It then closes every bank with one precharge, gives the device a programmable number of auto-refresh commands, and writes the supplied mode word into the mode register. Once the guard time after that write has run out, it raises a done flag.

All waits are counted in clock cycles. Each cycle count comes from a time in nanoseconds and the clock period in picoseconds, rounded up. By default the refreshes come before the mode write. A parameter selects the other order. After done is raised the block keeps driving no-operation commands, so a controller can take over the pins. Reset at any moment starts the whole bring-up again.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst` is high, and from then on until `init_done` rises, `sd_cke` is 1 and `sd_dqm` is 2'b11. During reset the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no-operation) and `init_done` is 0.
- R2: After `rst` falls, the pins show no-operation for exactly SETTLE cycles, where SETTLE = ceil(SETTLE_NS*1000/CLK_PS). This is 50000 cycles for 200 us at 4 ns. The precharge appears in cycle SETTLE+1, counting the first clock edge after release as the end of cycle 1.
- R3: The first command is a precharge, encoded 4'b0010, with address bit 10 driven high so that both banks are closed whatever BA holds.
- R4: Exactly REFRESH_CNT auto-refresh commands (encoded 4'b0001, with REFRESH_CNT of at least 2) follow. The first comes ceil(TRP_NS/period) cycles after the precharge, and each later one comes ceil(TRC_NS/period) cycles after the one before it. At 4 ns these are 4 and 14 cycles.
- R5: With the default order, a mode register write (encoded 4'b0000) follows the last refresh after the refresh-cycle gap. It carries `mode_word` on `sd_addr` and 0 on `sd_ba`.
- R6: `init_done` rises exactly MRD_CYC (2) cycles after the mode write and never earlier. Only no-operation appears between the two.
- R7: Once `init_done` is 1 it stays 1 until reset, and the pins show only no-operation.
- R8: Asserting `rst` in the middle of the sequence returns the pins to the R1 reset state on the next edge, and a later release replays the whole sequence from the settle phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode_word | input | 12 | Value loaded into the mode register |
| sd_cke | output | 1 | Clock enable to the SDRAM |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | 12 | Address bus |
| sd_dqm | output | 2 | Byte masks, upper and lower |
| init_done | output | 1 | High once the device may accept normal commands |

## Verification
The bench records every non-NOP command together with the cycle in which it appears. It then compares those cycles with positions it computes from the time parameters. An off-by-one in any counter load therefore shows up as a precharge, refresh or mode write one cycle early or late. It also catches a missing or extra refresh when the count is set to three. A design that raised done on the mode write, or one cycle after it, would breach the two-cycle guard, and a precharge with address bit 10 low would leave one bank open. A reset is applied halfway through the refreshes, and the pins are checked to show that a design that did not clear its refresh count or its done flag would skip steps on the replay.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

    // Command encoding on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_PRE = 4'b0010,
        CMD_REF = 4'b0001,
        CMD_MRS = 4'b0000
    } sd_cmd_e;

    // Each waiting state names the action taken when the gap timer expires
    typedef enum logic [2:0] {
        ST_W_PRE,
        ST_W_REF,
        ST_W_MRS,
        ST_W_RDY,
        ST_DONE
    } sdinit_state_e;

    function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/sdinit_wait_timer.sv
module sdinit_wait_timer #(
    parameter int unsigned      CNT_W   = 16,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = val_i;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q.cnt <= RST_VAL;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign zero_o = (tmr_q.cnt == '0);

    // Once expired and not reloaded, the timer stays expired (supports R4 gap lengths)
    p_timer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (zero_o && !load_i) |=> zero_o);

    // A load of a non-zero value clears the expired flag on the next cycle (R4)
    p_timer_load_r4: assert property (@(posedge clk) disable iff (rst)
        (load_i && val_i != '0) |=> !zero_o);

endmodule

// File: rtl/sdinit_pin_driver.sv
module sdinit_pin_driver
    import sdinit_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  sd_cmd_e           cmd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              ba_i,
    input  logic              done_set_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        dqm_o,
    output logic              done_o
);

    typedef struct packed {
        logic              cke;
        sd_cmd_e           cmd;
        logic              ba;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        dqm;
        logic              done;
    } pins_t;

    pins_t pins_d, pins_q;

    always_comb begin
        pins_d      = pins_q;
        pins_d.cke  = 1'b1;
        pins_d.dqm  = 2'b11;
        pins_d.cmd  = cmd_i;
        pins_d.addr = addr_i;
        pins_d.ba   = ba_i;
        pins_d.done = pins_q.done | done_set_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q.cke  <= 1'b1;
            pins_q.cmd  <= CMD_NOP;
            pins_q.ba   <= 1'b0;
            pins_q.addr <= '0;
            pins_q.dqm  <= 2'b11;
            pins_q.done <= 1'b0;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign cke_o   = pins_q.cke;
    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins_q.cmd;
    assign ba_o    = pins_q.ba;
    assign addr_o  = pins_q.addr;
    assign dqm_o   = pins_q.dqm;
    assign done_o  = pins_q.done;

    // The done flag is sticky until reset (R7)
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o);

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdinit_pkg::*;
#(
    parameter int unsigned CLK_PS        = 4000,
    parameter int unsigned SETTLE_NS     = 200000,
    parameter int unsigned TRP_NS        = 15,
    parameter int unsigned TRC_NS        = 55,
    parameter int unsigned MRD_CYC       = 2,
    parameter int unsigned REFRESH_CNT   = 2,
    parameter bit          REFRESH_FIRST = 1'b1,
    parameter int unsigned ADDR_W        = 12,
    parameter int unsigned AP_BIT        = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] mode_word,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [1:0]        sd_dqm,
    output logic              init_done
);

    localparam int unsigned SETTLE_CYC = cyc_ceil(SETTLE_NS * 1000, CLK_PS);
    localparam int unsigned TRP_CYC    = cyc_ceil(TRP_NS * 1000, CLK_PS);
    localparam int unsigned TRC_CYC    = cyc_ceil(TRC_NS * 1000, CLK_PS);
    localparam int unsigned MAX_CYC    = (SETTLE_CYC > TRC_CYC) ? SETTLE_CYC : TRC_CYC;
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
    localparam int unsigned REF_W      = $clog2(REFRESH_CNT + 1);

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC);
    localparam logic [CNT_W-1:0] TRP_LD    = CNT_W'(TRP_CYC - 1);
    localparam logic [CNT_W-1:0] TRC_LD    = CNT_W'(TRC_CYC - 1);
    localparam logic [CNT_W-1:0] MRD_LD    = CNT_W'(MRD_CYC - 1);
    localparam logic [REF_W-1:0] REF_LAST  = REF_W'(REFRESH_CNT - 1);

    // Order of the refresh and mode-write steps is chosen by REFRESH_FIRST
    localparam sdinit_state_e AFTER_PRE  = REFRESH_FIRST ? ST_W_REF : ST_W_MRS;
    localparam sdinit_state_e AFTER_REFS = REFRESH_FIRST ? ST_W_MRS : ST_W_RDY;
    localparam sdinit_state_e AFTER_MRS  = REFRESH_FIRST ? ST_W_RDY : ST_W_REF;

    typedef struct packed {
        sdinit_state_e    st;
        logic [REF_W-1:0] ref_cnt;
    } fsm_t;

    fsm_t              fsm_d, fsm_q;
    sd_cmd_e           cmd_nx;
    logic [ADDR_W-1:0] addr_nx;
    logic              ba_nx;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic              done_set;

    sdinit_wait_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (SETTLE_LD)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    always_comb begin
        fsm_d    = fsm_q;
        cmd_nx   = CMD_NOP;
        addr_nx  = '0;
        ba_nx    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        done_set = 1'b0;
        if (tmr_zero) begin
            unique case (fsm_q.st)
                ST_W_PRE: begin
                    cmd_nx          = CMD_PRE;
                    addr_nx[AP_BIT] = 1'b1;
                    tmr_load        = 1'b1;
                    tmr_val         = TRP_LD;
                    fsm_d.st        = AFTER_PRE;
                end
                ST_W_REF: begin
                    cmd_nx        = CMD_REF;
                    tmr_load      = 1'b1;
                    tmr_val       = TRC_LD;
                    fsm_d.ref_cnt = fsm_q.ref_cnt + 1'b1;
                    if (fsm_q.ref_cnt == REF_LAST) begin
                        fsm_d.st = AFTER_REFS;
                    end
                end
                ST_W_MRS: begin
                    cmd_nx   = CMD_MRS;
                    addr_nx  = mode_word;
                    tmr_load = 1'b1;
                    tmr_val  = MRD_LD;
                    fsm_d.st = AFTER_MRS;
                end
                ST_W_RDY: begin
                    done_set = 1'b1;
                    fsm_d.st = ST_DONE;
                end
                ST_DONE: begin
                end
                default: fsm_d.st = ST_W_PRE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.st      <= ST_W_PRE;
            fsm_q.ref_cnt <= '0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    sdinit_pin_driver #(
        .ADDR_W (ADDR_W)
    ) i_pins (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd_nx),
        .addr_i     (addr_nx),
        .ba_i       (ba_nx),
        .done_set_i (done_set),
        .cke_o      (sd_cke),
        .cs_n_o     (sd_cs_n),
        .ras_n_o    (sd_ras_n),
        .cas_n_o    (sd_cas_n),
        .we_n_o     (sd_we_n),
        .ba_o       (sd_ba),
        .addr_o     (sd_addr),
        .dqm_o      (sd_dqm),
        .done_o     (init_done)
    );

    logic [3:0] pin_cmd;
    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    p_hold_masks_r1: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> (sd_cke && sd_dqm == 2'b11));

    p_pre_all_r3: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_PRE) |-> sd_addr[AP_BIT]);

    p_ref_bound_r4: assert property (@(posedge clk) disable iff (rst)
        fsm_q.ref_cnt <= REF_W'(REFRESH_CNT));

    p_mrs_payload_r5: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_MRS) |-> (sd_addr == $past(mode_word) && !sd_ba));

    p_mrs_guard_r6: assert property (@(posedge clk) disable iff (rst)
        (pin_cmd == CMD_MRS) |=> (pin_cmd == CMD_NOP && !init_done));

    p_quiet_after_done_r7: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (pin_cmd == CMD_NOP));

endmodule

// File: tb/test_sdram_powerup_seq.sv
module test_sdram_powerup_seq;

    localparam int SETTLE = 50000;  // ceil(200 us / 4 ns)
    localparam int TRP    = 4;      // ceil(15 ns / 4 ns)
    localparam int TRC    = 14;     // ceil(55 ns / 4 ns)
    localparam int MRD    = 2;
    localparam int NREF   = 3;
    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mode_word = '0;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, init_done;
    logic [11:0] sd_addr;
    logic [1:0]  sd_dqm;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;

    sdram_powerup_seq #(
        .REFRESH_CNT (NREF)
    ) i_sdram_powerup_seq (
        .clk       (clk),
        .rst       (rst),
        .mode_word (mode_word),
        .sd_cke    (sd_cke),
        .sd_cs_n   (sd_cs_n),
        .sd_ras_n  (sd_ras_n),
        .sd_cas_n  (sd_cas_n),
        .sd_we_n   (sd_we_n),
        .sd_ba     (sd_ba),
        .sd_addr   (sd_addr),
        .sd_dqm    (sd_dqm),
        .init_done (init_done)
    );

    function automatic logic [3:0] pins_cmd();
        return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(pins_cmd() == C_NOP, "R1", "reset command", pins_cmd(), C_NOP);
        chk(sd_cke == 1'b1 && sd_dqm == 2'b11, "R1", "reset cke/dqm", {sd_cke, sd_dqm}, 3'b111);
        chk(init_done == 1'b0, "R1", "reset done", init_done, 0);
    endtask

    task automatic t_sequence(input logic [11:0] mode);
        int         ev_n;
        int         ev_cyc [8];
        logic [3:0] ev_cmd [8];
        logic [11:0] ev_addr [8];
        logic       ev_ba [8];
        int         rdy_cyc;
        int         pin_bad;
        int         quiet_bad;
        int         p0;
        mode_word = mode;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ev_n = 0; rdy_cyc = -1; pin_bad = 0; quiet_bad = 0;
        for (int c = 1; c <= SETTLE + 200 && rdy_cyc < 0; c++) begin
            @(negedge clk);
            if (init_done) begin
                rdy_cyc = c;
            end else begin
                if (!(sd_cke && sd_dqm == 2'b11)) pin_bad++;
                if (pins_cmd() != C_NOP) begin
                    if (ev_n < 8) begin
                        ev_cyc[ev_n]  = c;
                        ev_cmd[ev_n]  = pins_cmd();
                        ev_addr[ev_n] = sd_addr;
                        ev_ba[ev_n]   = sd_ba;
                    end
                    ev_n++;
                end
            end
        end
        p0 = SETTLE + 1;
        chk(pin_bad == 0, "R1", "cycles with cke/dqm low before done", pin_bad, 0);
        chk(ev_n == NREF + 2, "R4", "number of commands issued", ev_n, NREF + 2);
        if (ev_n >= NREF + 2) begin
            chk(ev_cyc[0] == p0, "R2", "precharge cycle after settle", ev_cyc[0], p0);
            chk(ev_cmd[0] == C_PRE, "R3", "first command", ev_cmd[0], C_PRE);
            chk(ev_addr[0][10] == 1'b1, "R3", "precharge A10", ev_addr[0][10], 1);
            for (int i = 0; i < NREF; i++) begin
                chk(ev_cmd[1+i] == C_REF, "R4", "refresh command", ev_cmd[1+i], C_REF);
                chk(ev_cyc[1+i] == p0 + TRP + i * TRC, "R4", "refresh cycle",
                    ev_cyc[1+i], p0 + TRP + i * TRC);
            end
            chk(ev_cmd[NREF+1] == C_MRS, "R5", "mode write command", ev_cmd[NREF+1], C_MRS);
            chk(ev_cyc[NREF+1] == p0 + TRP + NREF * TRC, "R5", "mode write cycle",
                ev_cyc[NREF+1], p0 + TRP + NREF * TRC);
            chk(ev_addr[NREF+1] == mode, "R5", "mode write address", ev_addr[NREF+1], mode);
            chk(ev_ba[NREF+1] == 1'b0, "R5", "mode write bank", ev_ba[NREF+1], 0);
            chk(rdy_cyc == ev_cyc[NREF+1] + MRD, "R6", "done cycle", rdy_cyc, ev_cyc[NREF+1] + MRD);
        end
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (!init_done || pins_cmd() != C_NOP) quiet_bad++;
        end
        chk(quiet_bad == 0, "R7", "cycles after done not quiet", quiet_bad, 0);
    endtask

    task automatic t_reset_midway();
        int early;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        early = 0;
        for (int c = 1; c <= SETTLE + 1 + TRP + 5; c++) begin
            @(negedge clk);
            if (init_done) early++;
        end
        chk(early == 0, "R6", "done high before mode write", early, 0);
        rst = 1'b1;
        @(negedge clk);
        chk(pins_cmd() == C_NOP, "R8", "command after mid reset", pins_cmd(), C_NOP);
        chk(sd_cke == 1'b1 && sd_dqm == 2'b11, "R8", "cke/dqm after mid reset", {sd_cke, sd_dqm}, 3'b111);
        chk(init_done == 1'b0, "R8", "done after mid reset", init_done, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL R6: watchdog expired actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_sequence(12'h032);
        t_reset_midway();
        // R8: replay from the start with a different mode word
        t_sequence(12'h2A7);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule